// File: doc/BRIEF.md
# Indirect auto-incrementing register port

This block is the host-facing register access unit of a bus interface controller. The host sees only two byte-wide locations, chosen by `hst_port`. The first is the address/status port. Writing it selects one of 26 internal byte registers. Reading it returns a live auxiliary status byte and has no side effect. The second is the value port. Each access there reads or writes the selected register and then moves the pointer on by one. A multi-byte field can therefore be loaded with one address write followed by a run of value writes. Two examples are a 12-byte command block placed from register 3 onward, and a 24-bit transfer count held most significant byte first in registers 18 to 20.

A write to the command register (24) hands a command code to an external engine, which is a stub here. The write raises two flags, busy and command-in-progress. The engine clears command-in-progress with an acknowledge pulse. Its done pulse clears both flags, raises the interrupt and loads the result byte into the status register (23). While busy is set, only the command register (24), the data register (25) and the auxiliary status byte can be reached. While command-in-progress is set, the command register is closed as well.

Top module: `ireg_port`

## Requirements
- R1: A host write to the address port loads the pointer with the written value, saturated to 25. A host read of that port returns the auxiliary status byte and leaves the pointer unchanged.
- R2: Every value-port access advances the pointer by one, except when the pointer is at 25 (data register). There it holds, so repeated accesses stream through the data register.
- R3: The auxiliary status byte has the following layout: bit7 interrupt pending, bit6 last command ignored, bit5 busy, bit4 command in progress, bits 3:2 always zero, bit1 parity error, bit0 data buffer ready. Bit1 is set by an `eng_perr` pulse and is sticky. Bit0 follows `eng_dbr`.
- R4: `xfer_count` equals {reg18, reg19, reg20}, most significant byte first, and reaches 24'hFFFFFF.
- R5: Register 17 stores the period in bits 6:4 and the offset in bits 3:0. An offset above 12 is stored as 12, and bit7 always reads zero. Its fields drive `sync_period` and `sync_offset`.
- R6: A command write accepted while command-in-progress is clear stores the code. On the next cycle it sets busy and command-in-progress, and it pulses `cmd_start` high for exactly one cycle, with `cmd_code` carrying the code.
- R7: While busy is set, a value-port access to any register below 24 has no effect on a write and returns zero on a read. The command and data registers stay reachable.
- R8: While command-in-progress is set, a command write is dropped: the code and the flags are unchanged, `cmd_start` stays low, and last-command-ignored is set. A read of the command register returns zero.
- R9: `eng_ack` clears command-in-progress. `eng_done` clears busy and command-in-progress, sets interrupt pending (which drives `irq`), and loads `eng_status` into register 23.
- R10: A host read of register 23 clears interrupt pending, last-command-ignored and parity error.
- R11: After reset, the pointer, every register and every flag are zero.
- R12: Host writes to register 23 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_cs | input | 1 | Host access strobe, one access per cycle |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_port | input | 1 | 0 = address/status port, 1 = value port |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data (combinational for the current access) |
| eng_ack | input | 1 | Engine accepted command, clears command-in-progress |
| eng_done | input | 1 | Engine finished command |
| eng_status | input | 8 | Result byte captured into register 23 on done |
| eng_perr | input | 1 | Parity error pulse |
| eng_dbr | input | 1 | Data buffer ready level |
| cmd_start | output | 1 | One-cycle command launch pulse |
| cmd_code | output | 8 | Stored command code |
| xfer_count | output | 24 | Transfer count |
| sync_offset | output | 4 | Synchronous offset field |
| sync_period | output | 3 | Synchronous period field |
| irq | output | 1 | Interrupt pending |

## Verification
The pointer is tried with three access patterns: a long run of writes and read-backs over the 12-byte command block, an auxiliary read placed between an address load and a value read, and repeated accesses at the data register. Together these separate a step on every access, a missing step, a step on status reads, and a stop or wrap at the end. Command handling is driven through all three busy levels in turn: command-in-progress, busy alone, and idle after done. At each level both a gated register and the command register are probed, which shows whether the two gating levels are told apart. Field boundaries are covered by a saturating address, an all-ones count, and a sync offset above and below the limit.

// File: rtl/ireg_pkg.sv
package ireg_pkg;
    localparam int DW        = 8;
    localparam int NREG      = 26;
    localparam int PW        = $clog2(NREG);
    localparam int CNT_BYTES = 3;
    localparam int CW        = CNT_BYTES * DW;
    localparam int OFS_W     = 4;
    localparam int PER_W     = 3;
    localparam int MAX_OFS   = 12;

    typedef logic [PW-1:0] rptr_t;
    typedef logic [DW-1:0] byte_t;

    localparam rptr_t IDX_SYNC = rptr_t'(17);
    localparam rptr_t IDX_CNT  = rptr_t'(18);
    localparam rptr_t IDX_STAT = rptr_t'(23);
    localparam rptr_t IDX_CMD  = rptr_t'(24);
    localparam rptr_t IDX_DATA = rptr_t'(25);
    localparam rptr_t IDX_LAST = rptr_t'(NREG - 1);

    typedef struct packed {
        logic       int_p;
        logic       lci;
        logic       busy;
        logic       cip;
        logic [1:0] rsv;
        logic       perr;
        logic       dbr;
    } aux_t;

    function automatic byte_t sync_fix(input byte_t v);
        logic [OFS_W-1:0] ofs;
        ofs = v[OFS_W-1:0];
        if (ofs > OFS_W'(MAX_OFS))
            ofs = OFS_W'(MAX_OFS);
        return {1'b0, v[OFS_W+PER_W-1:OFS_W], ofs};
    endfunction

    function automatic rptr_t ptr_sat(input byte_t v);
        if (v > byte_t'(NREG - 1))
            return IDX_LAST;
        return rptr_t'(v);
    endfunction
endpackage

// File: rtl/ireg_ptr.sv
module ireg_ptr
    import ireg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  byte_t load_val,
    input  logic  step,
    output rptr_t ptr
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (load)
            ptr <= ptr_sat(load_val);
        else if (step && ptr < IDX_DATA && ptr < IDX_LAST)
            ptr <= ptr + rptr_t'(1);
    end
endmodule

// File: rtl/ireg_bank.sv
module ireg_bank
    import ireg_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  rptr_t                  wr_idx,
    input  byte_t                  wr_data,
    input  logic                   st_load,
    input  byte_t                  st_val,
    output logic [NREG-1:0][DW-1:0] regs
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == int'(IDX_STAT)) begin : g_stat
            always_ff @(posedge clk) begin
                if (rst)
                    regs[i] <= '0;
                else if (st_load)
                    regs[i] <= st_val;
            end
        end else if (i == int'(IDX_SYNC)) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst)
                    regs[i] <= '0;
                else if (wr_en && wr_idx == rptr_t'(i))
                    regs[i] <= sync_fix(wr_data);
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)
                    regs[i] <= '0;
                else if (wr_en && wr_idx == rptr_t'(i))
                    regs[i] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/ireg_flags.sv
module ireg_flags
    import ireg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_acc,
    input  logic cmd_drop,
    input  logic eng_ack,
    input  logic eng_done,
    input  logic eng_perr,
    input  logic stat_rd,
    output logic busy,
    output logic cip,
    output logic int_p,
    output logic lci,
    output logic perr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cip   <= 1'b0;
            int_p <= 1'b0;
            lci   <= 1'b0;
            perr  <= 1'b0;
        end else begin
            if (eng_ack)
                cip <= 1'b0;
            if (eng_done) begin
                busy <= 1'b0;
                cip  <= 1'b0;
            end
            if (cmd_acc) begin
                busy <= 1'b1;
                cip  <= 1'b1;
            end
            if (eng_done)
                int_p <= 1'b1;
            else if (stat_rd)
                int_p <= 1'b0;
            if (cmd_drop)
                lci <= 1'b1;
            else if (stat_rd)
                lci <= 1'b0;
            if (eng_perr)
                perr <= 1'b1;
            else if (stat_rd)
                perr <= 1'b0;
        end
    end
endmodule

// File: rtl/ireg_port.sv
module ireg_port
    import ireg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hst_cs,
    input  logic             hst_we,
    input  logic             hst_port,
    input  logic [7:0]       hst_wdata,
    output logic [7:0]       hst_rdata,
    input  logic             eng_ack,
    input  logic             eng_done,
    input  logic [7:0]       eng_status,
    input  logic             eng_perr,
    input  logic             eng_dbr,
    output logic             cmd_start,
    output logic [7:0]       cmd_code,
    output logic [23:0]      xfer_count,
    output logic [3:0]       sync_offset,
    output logic [2:0]       sync_period,
    output logic             irq
);
    rptr_t                   ptr;
    logic [NREG-1:0][DW-1:0] regs;
    logic busy, cip, int_p, lci, perr;
    logic val_acc, ptr_ld, gated, wr_ok, cmd_wr, cmd_acc, cmd_drop, stat_rd;
    aux_t aux;

    assign val_acc  = hst_cs && hst_port;
    assign ptr_ld   = hst_cs && !hst_port && hst_we;
    assign gated    = (busy && ptr < IDX_CMD) || (cip && ptr == IDX_CMD);
    assign cmd_wr   = val_acc && hst_we && ptr == IDX_CMD;
    assign cmd_acc  = cmd_wr && !cip;
    assign cmd_drop = cmd_wr && cip;
    assign wr_ok    = val_acc && hst_we && !gated && ptr != IDX_STAT;
    assign stat_rd  = val_acc && !hst_we && !gated && ptr == IDX_STAT;

    ireg_ptr u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_ld),
        .load_val (hst_wdata),
        .step     (val_acc),
        .ptr      (ptr)
    );

    ireg_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_ok),
        .wr_idx  (ptr),
        .wr_data (hst_wdata),
        .st_load (eng_done),
        .st_val  (eng_status),
        .regs    (regs)
    );

    ireg_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .cmd_acc  (cmd_acc),
        .cmd_drop (cmd_drop),
        .eng_ack  (eng_ack),
        .eng_done (eng_done),
        .eng_perr (eng_perr),
        .stat_rd  (stat_rd),
        .busy     (busy),
        .cip      (cip),
        .int_p    (int_p),
        .lci      (lci),
        .perr     (perr)
    );

    always_comb begin
        aux       = '0;
        aux.int_p = int_p;
        aux.lci   = lci;
        aux.busy  = busy;
        aux.cip   = cip;
        aux.perr  = perr;
        aux.dbr   = eng_dbr;
    end

    always_comb begin
        if (!hst_port)
            hst_rdata = aux;
        else if (gated)
            hst_rdata = '0;
        else
            hst_rdata = regs[ptr];
    end

    always_ff @(posedge clk) begin
        if (rst)
            cmd_start <= 1'b0;
        else
            cmd_start <= cmd_acc;
    end

    for (genvar b = 0; b < CNT_BYTES; b++) begin : g_cnt
        assign xfer_count[CW-1-b*DW -: DW] = regs[int'(IDX_CNT) + b];
    end

    assign cmd_code    = regs[IDX_CMD];
    assign sync_offset = regs[IDX_SYNC][OFS_W-1:0];
    assign sync_period = regs[IDX_SYNC][OFS_W+PER_W-1:OFS_W];
    assign irq         = int_p;
endmodule

// File: rtl/ireg_port_chk.sv
module ireg_port_chk
    import ireg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       hst_cs,
    input logic       hst_we,
    input logic       hst_port,
    input logic [7:0] hst_rdata,
    input logic       eng_done,
    input logic       cmd_start,
    input logic       irq,
    input logic       busy,
    input logic       cip,
    input rptr_t      ptr
);
    AST_AUX_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
        (hst_cs && !hst_port && !hst_we) |=> $stable(ptr)); // R1

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (hst_cs && hst_port && ptr < IDX_DATA) |=> ptr == $past(ptr) + rptr_t'(1)); // R2

    AST_PTR_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (hst_cs && hst_port && ptr == IDX_DATA) |=> ptr == IDX_DATA); // R2

    AST_AUX_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        !hst_port |-> hst_rdata[3:2] == 2'b00); // R3

    AST_START_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> $past(hst_cs && hst_we && hst_port && ptr == IDX_CMD)); // R6

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> (busy && cip)); // R6

    AST_GATED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (hst_port && busy && ptr < IDX_CMD) |-> hst_rdata == 8'h00); // R7

    AST_CIP_CMD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (hst_port && cip && ptr == IDX_CMD) |-> hst_rdata == 8'h00); // R8

    AST_DONE_IRQ: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> (irq && !busy)); // R9
endmodule

bind ireg_port ireg_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .hst_cs    (hst_cs),
    .hst_we    (hst_we),
    .hst_port  (hst_port),
    .hst_rdata (hst_rdata),
    .eng_done  (eng_done),
    .cmd_start (cmd_start),
    .irq       (irq),
    .busy      (busy),
    .cip       (cip),
    .ptr       (ptr)
);

// File: tb/sim_ireg_port.sv
module sim_ireg_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hst_cs = 1'b0, hst_we = 1'b0, hst_port = 1'b0;
    logic [7:0]  hst_wdata = '0;
    logic [7:0]  hst_rdata;
    logic        eng_ack = 1'b0, eng_done = 1'b0, eng_perr = 1'b0, eng_dbr = 1'b0;
    logic [7:0]  eng_status = '0;
    logic        cmd_start;
    logic [7:0]  cmd_code;
    logic [23:0] xfer_count;
    logic [3:0]  sync_offset;
    logic [2:0]  sync_period;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #4 clk = ~clk;

    ireg_port u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic acc(input logic port, input logic we, input logic [7:0] wd, output logic [7:0] rd);
        @(negedge clk);
        hst_cs = 1'b1; hst_port = port; hst_we = we; hst_wdata = wd;
        #1 rd = hst_rdata;
        @(posedge clk);
        #1 hst_cs = 1'b0; hst_we = 1'b0;
    endtask

    task automatic set_ptr(input logic [7:0] a);
        logic [7:0] d;
        acc(1'b0, 1'b1, a, d);
    endtask
    task automatic wr_val(input logic [7:0] v);
        logic [7:0] d;
        acc(1'b1, 1'b1, v, d);
    endtask
    task automatic rd_val(output logic [7:0] v);
        acc(1'b1, 1'b0, 8'h00, v);
    endtask
    task automatic rd_aux(output logic [7:0] v);
        acc(1'b0, 1'b0, 8'h00, v);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd_aux(d);           chk("R11 aux", d, 8'h00);
        chk("R11 count", xfer_count, 24'h0);
        chk("R11 irq", irq, 1'b0);
        rd_val(d);           chk("R11 reg0", d, 8'h00);
    endtask

    task automatic t_pointer;
        logic [7:0] d;
        set_ptr(8'd3);
        for (int i = 0; i < 12; i++) wr_val(8'h10 + 8'(i));
        set_ptr(8'd3);
        for (int i = 0; i < 12; i++) begin
            rd_val(d); chk("R2 block readback", d, 8'h10 + 8'(i));
        end
        set_ptr(8'd5);
        rd_aux(d);
        rd_val(d);           chk("R1 aux read keeps pointer", d, 8'h12);
        set_ptr(8'd25);
        wr_val(8'hA1);
        wr_val(8'hB2);
        rd_val(d);           chk("R2 data hold", d, 8'hB2);
        rd_val(d);           chk("R2 data hold again", d, 8'hB2);
        set_ptr(8'd4);
        set_ptr(8'd200);
        rd_val(d);           chk("R1 saturate to 25", d, 8'hB2);
    endtask

    task automatic t_count;
        set_ptr(8'd18);
        wr_val(8'h12); wr_val(8'h34); wr_val(8'h56);
        chk("R4 count", xfer_count, 24'h123456);
        set_ptr(8'd18);
        wr_val(8'hFF); wr_val(8'hFF); wr_val(8'hFF);
        chk("R4 count max", xfer_count, 24'hFFFFFF);
    endtask

    task automatic t_sync;
        logic [7:0] d;
        set_ptr(8'd17); wr_val(8'h5F);
        set_ptr(8'd17); rd_val(d);
        chk("R5 clamp", d, 8'h5C);
        chk("R5 offset out", sync_offset, 4'd12);
        chk("R5 period out", sync_period, 3'd5);
        set_ptr(8'd17); wr_val(8'hF7);
        set_ptr(8'd17); rd_val(d);
        chk("R5 bit7 zero", d, 8'h77);
    endtask

    task automatic pulse_ack;
        @(negedge clk); eng_ack = 1'b1;
        @(posedge clk); #1 eng_ack = 1'b0;
    endtask
    task automatic pulse_done(input logic [7:0] st);
        @(negedge clk); eng_done = 1'b1; eng_status = st;
        @(posedge clk); #1 eng_done = 1'b0;
    endtask

    task automatic t_command;
        logic [7:0] d;
        set_ptr(8'd24);
        wr_val(8'h21);
        chk("R6 start pulse", cmd_start, 1'b1);
        chk("R6 code", cmd_code, 8'h21);
        @(posedge clk); #1;
        chk("R6 pulse one cycle", cmd_start, 1'b0);
        rd_aux(d);           chk("R6 busy+cip", d, 8'h30);
        set_ptr(8'd24);
        wr_val(8'h05);
        chk("R8 no start", cmd_start, 1'b0);
        chk("R8 code kept", cmd_code, 8'h21);
        rd_aux(d);           chk("R8 lci set", d, 8'h70);
        set_ptr(8'd24); rd_val(d);
        chk("R8 cmd read zero", d, 8'h00);
        set_ptr(8'd2); wr_val(8'h99);
        pulse_ack;
        rd_aux(d);           chk("R9 ack clears cip", d, 8'h60);
        set_ptr(8'd24); rd_val(d);
        chk("R7 cmd reachable when busy", d, 8'h21);
        set_ptr(8'd3); rd_val(d);
        chk("R7 gated read zero", d, 8'h00);
        pulse_done(8'h16);
        chk("R9 irq", irq, 1'b1);
        rd_aux(d);           chk("R9 done flags", d, 8'hC0);
        set_ptr(8'd2); rd_val(d);
        chk("R7 gated write no effect", d, 8'h00);
        set_ptr(8'd23); rd_val(d);
        chk("R9 status loaded", d, 8'h16);
        rd_aux(d);           chk("R10 flags cleared", d, 8'h00);
        chk("R10 irq low", irq, 1'b0);
    endtask

    task automatic t_perr_dbr;
        logic [7:0] d;
        @(negedge clk); eng_perr = 1'b1;
        @(posedge clk); #1 eng_perr = 1'b0;
        rd_aux(d);           chk("R3 perr sticky", d, 8'h02);
        eng_dbr = 1'b1;
        rd_aux(d);           chk("R3 dbr", d, 8'h03);
        set_ptr(8'd23); wr_val(8'hAA);
        set_ptr(8'd23); rd_val(d);
        chk("R12 status write ignored", d, 8'h16);
        rd_aux(d);           chk("R10 perr cleared", d, 8'h01);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset;
        t_pointer;
        t_count;
        t_sync;
        t_command;
        t_perr_dbr;
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule